// File: doc/BRIEF.md
# Flow Lookup Result Merger and Action Header Inserter

This block is the last step of a flow-table lookup stage in a packet switch. Each packet has one lookup result. The result carries an exact-match outcome (hit flag, entry index, action) and a wildcard outcome (a per-entry hit vector and one action per wildcard entry). The block chooses one outcome under a fixed precedence and queues the decision in arrival order. When the packet's first word is present, it writes the decision as one extra word ahead of the packet and passes the packet on to the output queues.

When the decision is made, the block also performs a read-modify-write on the chosen entry's statistics. The counter storage is outside the block and is reached through a combinational read port and a write strobe. The packet count and the byte count both saturate. A packet with no matching entry is sent on marked for the host processor path, and no counter changes. A packet whose action has the discard bit set is consumed completely, and nothing is emitted for it.

Top module: `flow_result_merge`

## Requirements
- R1: When the exact-match hit is set, the decision uses the exact action and exact index, and its exact-source flag is 1, whatever the wildcard hit vector holds.
- R2: With no exact hit and at least one wildcard hit bit set, the decision uses the lowest-numbered set bit j. Its action is the slice of wcActions at bits [j*6 +: 6], its index is j, and its exact-source flag is 0.
- R3: With no hit in either table, the action is 6'b010000 (only the host-path bit set), the hit flag, source flag and index are 0, and cntWrEn stays low for that packet.
- R4: The inserted word holds the action in bits [5:0], the hit flag in bit 6, the exact-source flag in bit 7 and the index in bits [8 +: EX_IDX_W], with all higher bits zero. The action bits are: output-port bitmap in [3:0], host-path bit in 4, discard bit in 5. The inserted word comes out with outSof=1, one cycle before the first packet word. The packet words follow unchanged, and outEof is set on the last word.
- R5: When the chosen action has bit 5 set, every word of the packet is accepted and no word, header included, appears on the output.
- R6: On a hit, cntWrEn is raised for one cycle with cntSel=1 for the exact table (0 for wildcard) and cntIdx set to the entry. cntWrPkt is the value read plus one, held at 2^32-1 once it reaches that value.
- R7: In the same write, cntWrByte is the value read plus pktLen (taken from the first packet word), held at 2^48-1 instead of wrapping.
- R8: Results are queued up to FIFO_DEPTH ahead of packets and are applied to packets in arrival order. resReady is low while the queue is full.
- R9: pktReady stays low, and the first packet word is held, until a queued result is available for it.
- R10: During and just after reset, outValid and cntWrEn are low, pktReady is low and resReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| resValid | input | 1 | Lookup result present |
| resReady | output | 1 | Result queue has room |
| exHit | input | 1 | Exact-match hit |
| exIndex | input | EX_IDX_W | Exact-match entry index |
| exAction | input | 6 | Exact-match entry action |
| wcHit | input | WC_N | Wildcard per-entry hit vector |
| wcActions | input | WC_N*6 | Wildcard actions, entry j at [j*6 +: 6] |
| pktValid | input | 1 | Packet word present |
| pktReady | output | 1 | Packet word accepted |
| pktData | input | DATA_W | Packet word |
| pktSof | input | 1 | First word of packet |
| pktEof | input | 1 | Last word of packet |
| pktLen | input | LEN_W | Packet byte length, valid with first word |
| outValid | output | 1 | Output word valid |
| outData | output | DATA_W | Output word |
| outSof | output | 1 | Output start (inserted word) |
| outEof | output | 1 | Output last word |
| cntWrEn | output | 1 | Counter write strobe |
| cntSel | output | 1 | Counter table: 1 exact, 0 wildcard |
| cntIdx | output | EX_IDX_W | Counter entry index |
| cntRdPkt | input | 32 | Current packet count of addressed entry |
| cntRdByte | input | 48 | Current byte count of addressed entry |
| cntWrPkt | output | 32 | New packet count |
| cntWrByte | output | 48 | New byte count |

## Verification
The bench builds the block with four wildcard entries, a 4-bit exact index, a 32-bit word and a two-entry result queue. With these values it can step through both exact-hit states against all sixteen wildcard hit vectors. That covers every precedence outcome, the miss case, and discard actions from both tables. The small queue can be filled so that backpressure and ordering can be observed. Preloaded counters close to their maxima exercise both saturation limits.

// File: rtl/frm_pkg.sv
package frm_pkg;
  localparam int PORTS = 4;
  localparam int ACT_W = PORTS + 2;
  localparam logic [ACT_W-1:0] MISS_ACT = 6'b010000;

  typedef enum logic [1:0] {ST_IDLE, ST_BODY, ST_DROP} state_e;

  typedef struct packed {
    logic accept;
    logic emitHdr;
    logic passWord;
  } strobe_t;
endpackage

// File: rtl/frm_decide.sv
module frm_decide
  import frm_pkg::*;
#(
  parameter int EX_IDX_W = 15,
  parameter int WC_N = 32,
  parameter int DEPTH = 4,
  localparam int DEC_W = EX_IDX_W + ACT_W + 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  resValid,
  output logic                  resReady,
  input  logic                  exHit,
  input  logic [EX_IDX_W-1:0]   exIndex,
  input  logic [ACT_W-1:0]      exAction,
  input  logic [WC_N-1:0]       wcHit,
  input  logic [WC_N*ACT_W-1:0] wcActions,
  input  logic                  pop,
  output logic                  headValid,
  output logic [DEC_W-1:0]      head
);
  localparam int WC_IDX_W = (WC_N > 1) ? $clog2(WC_N) : 1;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic                wcFound;
  logic [WC_IDX_W-1:0] wcSel;
  logic [DEC_W-1:0]    decided;

  // lowest set hit bit wins among wildcard entries
  always_comb begin
    wcFound = 1'b0;
    wcSel = '0;
    for (int i = WC_N - 1; i >= 0; i--) begin
      if (wcHit[i]) begin
        wcFound = 1'b1;
        wcSel = WC_IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (exHit)
      decided = {exIndex, 1'b1, 1'b1, exAction};
    else if (wcFound)
      decided = {EX_IDX_W'(wcSel), 1'b0, 1'b1, wcActions[wcSel*ACT_W +: ACT_W]};
    else
      decided = {{EX_IDX_W{1'b0}}, 1'b0, 1'b0, MISS_ACT};
  end

  logic [DEC_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             push;

  assign resReady = (count < CNT_W'(DEPTH));
  assign push = resValid && resReady;
  assign headValid = (count != '0);
  assign head = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) begin
        mem[wrPtr] <= decided;
        wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      end
      if (pop)
        rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  p_pop_has_entry_r9: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> headValid);
endmodule

// File: rtl/frm_ctrl.sv
module frm_ctrl
  import frm_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    headValid,
  input  logic    headDrop,
  input  logic    pktValid,
  input  logic    pktSof,
  input  logic    pktEof,
  output logic    pktReady,
  output strobe_t strb
);
  state_e state, nxt;

  always_comb begin
    strb = '0;
    nxt = state;
    case (state)
      ST_IDLE: begin
        if (headValid && pktValid && pktSof) begin
          strb.accept = 1'b1;
          strb.emitHdr = !headDrop;
          nxt = headDrop ? ST_DROP : ST_BODY;
        end
      end
      ST_BODY: begin
        if (pktValid) begin
          strb.passWord = 1'b1;
          if (pktEof) nxt = ST_IDLE;
        end
      end
      ST_DROP: begin
        if (pktValid && pktEof) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign pktReady = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else state <= nxt;
  end

  p_ready_after_accept_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.accept |=> pktReady);
endmodule

// File: rtl/frm_datapath.sv
module frm_datapath
  import frm_pkg::*;
#(
  parameter int EX_IDX_W = 15,
  parameter int DATA_W = 64,
  parameter int LEN_W = 16,
  localparam int DEC_W = EX_IDX_W + ACT_W + 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [DEC_W-1:0]    head,
  input  logic [DATA_W-1:0]   pktData,
  input  logic                pktEof,
  input  logic [LEN_W-1:0]    pktLen,
  input  logic [31:0]         cntRdPkt,
  input  logic [47:0]         cntRdByte,
  output logic                outValid,
  output logic [DATA_W-1:0]   outData,
  output logic                outSof,
  output logic                outEof,
  output logic                cntWrEn,
  output logic                cntSel,
  output logic [EX_IDX_W-1:0] cntIdx,
  output logic [31:0]         cntWrPkt,
  output logic [47:0]         cntWrByte
);
  logic [48:0] byteSum;

  assign cntSel = head[ACT_W+1];
  assign cntIdx = head[ACT_W+2 +: EX_IDX_W];
  assign cntWrEn = strb.accept && head[ACT_W];
  assign cntWrPkt = (cntRdPkt == '1) ? cntRdPkt : cntRdPkt + 32'd1;
  assign byteSum = {1'b0, cntRdByte} + 49'(pktLen);
  assign cntWrByte = byteSum[48] ? '1 : byteSum[47:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outSof <= 1'b0;
      outEof <= 1'b0;
      outData <= '0;
    end else begin
      outValid <= strb.emitHdr || strb.passWord;
      outSof <= strb.emitHdr;
      outEof <= strb.passWord && pktEof;
      outData <= strb.emitHdr ? DATA_W'(head) : pktData;
    end
  end

  p_pkt_sat_r6: assert property (@(posedge clk) disable iff (!rstN)
    cntWrEn |-> (cntWrPkt >= cntRdPkt));
  p_byte_sat_r7: assert property (@(posedge clk) disable iff (!rstN)
    cntWrEn |-> (cntWrByte >= cntRdByte));
  p_hdr_then_out_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.emitHdr |=> (outValid && outSof));
endmodule

// File: rtl/flow_result_merge.sv
module flow_result_merge
  import frm_pkg::*;
#(
  parameter int EX_IDX_W = 15,
  parameter int WC_N = 32,
  parameter int FIFO_DEPTH = 4,
  parameter int DATA_W = 64,
  parameter int LEN_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  resValid,
  output logic                  resReady,
  input  logic                  exHit,
  input  logic [EX_IDX_W-1:0]   exIndex,
  input  logic [ACT_W-1:0]      exAction,
  input  logic [WC_N-1:0]       wcHit,
  input  logic [WC_N*ACT_W-1:0] wcActions,
  input  logic                  pktValid,
  output logic                  pktReady,
  input  logic [DATA_W-1:0]     pktData,
  input  logic                  pktSof,
  input  logic                  pktEof,
  input  logic [LEN_W-1:0]      pktLen,
  output logic                  outValid,
  output logic [DATA_W-1:0]     outData,
  output logic                  outSof,
  output logic                  outEof,
  output logic                  cntWrEn,
  output logic                  cntSel,
  output logic [EX_IDX_W-1:0]   cntIdx,
  input  logic [31:0]           cntRdPkt,
  input  logic [47:0]           cntRdByte,
  output logic [31:0]           cntWrPkt,
  output logic [47:0]           cntWrByte
);
  localparam int DEC_W = EX_IDX_W + ACT_W + 2;

  logic             headValid;
  logic [DEC_W-1:0] head;
  strobe_t          strb;

  frm_decide #(.EX_IDX_W(EX_IDX_W), .WC_N(WC_N), .DEPTH(FIFO_DEPTH)) u_decide (
    .clk, .rstN, .resValid, .resReady, .exHit, .exIndex, .exAction,
    .wcHit, .wcActions, .pop(strb.accept), .headValid, .head
  );

  frm_ctrl u_ctrl (
    .clk, .rstN, .headValid, .headDrop(head[ACT_W-1]),
    .pktValid, .pktSof, .pktEof, .pktReady, .strb
  );

  frm_datapath #(.EX_IDX_W(EX_IDX_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_dp (
    .clk, .rstN, .strb, .head, .pktData, .pktEof, .pktLen,
    .cntRdPkt, .cntRdByte, .outValid, .outData, .outSof, .outEof,
    .cntWrEn, .cntSel, .cntIdx, .cntWrPkt, .cntWrByte
  );
endmodule

// File: tb/flow_result_merge_bench.sv
`timescale 1ns/1ps
module flow_result_merge_bench;
  localparam int IW = 4;
  localparam int WN = 4;
  localparam int DW = 32;
  localparam int LW = 16;

  logic clk = 0, rstN = 0;
  logic resValid = 0, resReady, exHit = 0;
  logic [IW-1:0] exIndex = '0;
  logic [5:0] exAction;
  logic [WN-1:0] wcHit = '0;
  logic [WN*6-1:0] wcActions;
  logic pktValid = 0, pktReady, pktSof = 0, pktEof = 0;
  logic [DW-1:0] pktData = '0;
  logic [LW-1:0] pktLen = '0;
  logic outValid, outSof, outEof, cntWrEn, cntSel;
  logic [DW-1:0] outData;
  logic [IW-1:0] cntIdx;
  logic [31:0] cntRdPkt, cntWrPkt;
  logic [47:0] cntRdByte, cntWrByte;

  int checks = 0, fails = 0, wrSeen = 0;
  logic [31:0] exP [16]; logic [47:0] exB [16];
  logic [31:0] wcP [4];  logic [47:0] wcB [4];
  logic [31:0] eExP [16]; logic [47:0] eExB [16];
  logic [31:0] eWcP [4];  logic [47:0] eWcB [4];
  logic [DW-1:0] obsD [$]; logic obsS [$]; logic obsE [$];

  always #2.5 clk = ~clk;

  function automatic logic [5:0] exActOf(input logic [3:0] i);
    return (i == 4'd15) ? 6'b100000 : {1'b0, i[3], i};
  endfunction
  function automatic logic [5:0] wcActOf(input int j);
    case (j)
      0: return 6'b000011;
      1: return 6'b010100;
      2: return 6'b001000;
      default: return 6'b100000;
    endcase
  endfunction

  assign exAction = exActOf(exIndex);
  assign wcActions = {wcActOf(3), wcActOf(2), wcActOf(1), wcActOf(0)};
  assign cntRdPkt = cntSel ? exP[cntIdx] : wcP[cntIdx[1:0]];
  assign cntRdByte = cntSel ? exB[cntIdx] : wcB[cntIdx[1:0]];

  always @(posedge clk) if (cntWrEn) begin
    if (cntSel) begin exP[cntIdx] <= cntWrPkt; exB[cntIdx] <= cntWrByte; end
    else begin wcP[cntIdx[1:0]] <= cntWrPkt; wcB[cntIdx[1:0]] <= cntWrByte; end
  end

  always @(negedge clk) begin
    if (outValid) begin obsD.push_back(outData); obsS.push_back(outSof); obsE.push_back(outEof); end
    if (cntWrEn) wrSeen++;
  end

  flow_result_merge #(.EX_IDX_W(IW), .WC_N(WN), .FIFO_DEPTH(2), .DATA_W(DW), .LEN_W(LW))
    u_flow_result_merge (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s: actual %0h expected %0h", tag, act, exp); end
  endtask

  task automatic sendRes(input bit eh, input logic [3:0] ei, input logic [3:0] wh);
    bit ok;
    @(posedge clk); #1;
    resValid = 1; exHit = eh; exIndex = ei; wcHit = wh;
    do begin @(negedge clk); ok = resReady; @(posedge clk); #1; end while (!ok);
    resValid = 0;
  endtask

  task automatic sendPkt(input int n, input logic [15:0] len, input logic [31:0] seed);
    bit ok;
    @(posedge clk); #1;
    for (int w = 0; w < n; w++) begin
      pktValid = 1; pktData = seed + 32'(w); pktSof = (w == 0); pktEof = (w == n - 1); pktLen = len;
      do begin @(negedge clk); ok = pktReady; @(posedge clk); #1; end while (!ok);
    end
    pktValid = 0; pktSof = 0; pktEof = 0;
  endtask

  function automatic logic [11:0] expRec(input bit eh, input logic [3:0] ei, input logic [3:0] wh);
    if (eh) return {ei, 1'b1, 1'b1, exActOf(ei)};
    for (int j = 0; j < 4; j++) if (wh[j]) return {4'(j), 1'b0, 1'b1, wcActOf(j)};
    return 12'b0000_0_0_010000;
  endfunction

  task automatic modelCount(input logic [11:0] rec, input logic [15:0] len);
    logic [31:0] p; logic [48:0] b; logic [3:0] ix;
    ix = rec[11:8];
    p = rec[7] ? eExP[ix] : eWcP[ix[1:0]];
    b = {1'b0, rec[7] ? eExB[ix] : eWcB[ix[1:0]]} + 49'(len);
    p = (p == 32'hFFFF_FFFF) ? p : p + 1;
    if (b > 49'h0_FFFF_FFFF_FFFF) b = 49'h0_FFFF_FFFF_FFFF;
    if (rec[7]) begin eExP[ix] = p; eExB[ix] = b[47:0]; end
    else begin eWcP[ix[1:0]] = p; eWcB[ix[1:0]] = b[47:0]; end
  endtask

  task automatic checkPkt(input logic [11:0] rec, input int n, input logic [31:0] seed,
                          input logic [15:0] len, input string hdrTag);
    logic [3:0] ix; bit bodyOk;
    ix = rec[11:8];
    if (rec[5]) chk(obsD.size() == 0, "R5 dropped packet emitted words", 64'(obsD.size()), 0);
    else begin
      chk(obsD.size() == n + 1, "R4 word count", 64'(obsD.size()), 64'(n + 1));
      if (obsD.size() == n + 1) begin
        chk(obsD[0] == DW'(rec) && obsS[0] && !obsE[0], hdrTag, 64'(obsD[0]), 64'(rec));
        bodyOk = 1;
        for (int k = 1; k <= n; k++)
          if (obsD[k] != seed + 32'(k - 1) || obsS[k] || obsE[k] != (k == n)) bodyOk = 0;
        chk(bodyOk, "R4 body words", 64'(obsD[n]), 64'(seed + 32'(n - 1)));
      end
    end
    chk(wrSeen == (rec[6] ? 1 : 0), "R3/R6 counter write strobes", 64'(wrSeen), 64'(rec[6]));
    if (rec[6]) begin
      modelCount(rec, len);
      if (rec[7]) begin
        chk(exP[ix] == eExP[ix], "R6 exact packet count", 64'(exP[ix]), 64'(eExP[ix]));
        chk(exB[ix] == eExB[ix], "R7 exact byte count", 64'(exB[ix]), 64'(eExB[ix]));
      end else begin
        chk(wcP[ix[1:0]] == eWcP[ix[1:0]], "R6 wildcard packet count", 64'(wcP[ix[1:0]]), 64'(eWcP[ix[1:0]]));
        chk(wcB[ix[1:0]] == eWcB[ix[1:0]], "R7 wildcard byte count", 64'(wcB[ix[1:0]]), 64'(eWcB[ix[1:0]]));
      end
    end
  endtask

  task automatic doPacket(input bit eh, input logic [3:0] ei, input logic [3:0] wh,
                          input int n, input logic [15:0] len, input logic [31:0] seed);
    string tag;
    obsD.delete(); obsS.delete(); obsE.delete(); wrSeen = 0;
    sendRes(eh, ei, wh);
    sendPkt(n, len, seed);
    repeat (3) @(posedge clk);
    tag = eh ? "R1 exact precedence header" : (wh != 0 ? "R2 wildcard lowest header" : "R3 miss header");
    checkPkt(expRec(eh, ei, wh), n, seed, len, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin exP[i] = 0; exB[i] = 0; eExP[i] = 0; eExB[i] = 0; end
    for (int i = 0; i < 4; i++) begin wcP[i] = 0; wcB[i] = 0; eWcP[i] = 0; eWcB[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!outValid && !pktReady && resReady && !cntWrEn, "R10 reset state",
        {outValid, pktReady, resReady, cntWrEn}, 4'b0010);
    @(posedge clk); #1; rstN = 1;
    @(negedge clk);
    chk(!outValid && !pktReady && resReady && !cntWrEn, "R10 state after reset",
        {outValid, pktReady, resReady, cntWrEn}, 4'b0010);

    // sweep every exact-hit state against every wildcard hit vector
    for (int eh = 0; eh < 2; eh++)
      for (int wc = 0; wc < 16; wc++)
        doPacket(eh[0], 4'(wc), 4'(wc), 1 + wc % 3, 16'(40 + wc * 7), 32'(eh * 1000 + wc * 16));

    // R9: packet waits for its result
    obsD.delete(); obsS.delete(); obsE.delete(); wrSeen = 0;
    fork
      sendPkt(2, 16'd64, 32'hA000);
      begin
        repeat (5) @(negedge clk);
        chk(!pktReady && obsD.size() == 0, "R9 packet held without result",
            {pktReady, 31'(obsD.size())}, 0);
        sendRes(1'b1, 4'd2, 4'b0000);
      end
    join
    repeat (3) @(posedge clk);
    checkPkt(expRec(1'b1, 4'd2, 4'b0000), 2, 32'hA000, 16'd64, "R9 header after late result");

    // R8: two results queued ahead, queue full, then applied in order
    obsD.delete(); obsS.delete(); obsE.delete(); wrSeen = 0;
    sendRes(1'b0, 4'd0, 4'b0100);
    sendRes(1'b1, 4'd7, 4'b0001);
    @(negedge clk);
    chk(!resReady, "R8 resReady low when queue full", 64'(resReady), 0);
    sendPkt(1, 16'd10, 32'hB000);
    sendPkt(1, 16'd20, 32'hC000);
    repeat (3) @(posedge clk);
    chk(obsD.size() == 4, "R8 words for two packets", 64'(obsD.size()), 4);
    if (obsD.size() == 4) begin
      chk(obsD[0] == DW'(expRec(1'b0, 4'd0, 4'b0100)) && obsD[1] == 32'hB000,
          "R8 first packet first decision", 64'(obsD[0]), 64'(expRec(1'b0, 4'd0, 4'b0100)));
      chk(obsD[2] == DW'(expRec(1'b1, 4'd7, 4'b0001)) && obsD[3] == 32'hC000,
          "R8 second packet second decision", 64'(obsD[2]), 64'(expRec(1'b1, 4'd7, 4'b0001)));
    end
    modelCount(expRec(1'b0, 4'd0, 4'b0100), 16'd10);
    modelCount(expRec(1'b1, 4'd7, 4'b0001), 16'd20);
    chk(exP[7] == eExP[7] && wcP[2] == eWcP[2], "R6 counts after queued pair", 64'(exP[7]), 64'(eExP[7]));

    // R6/R7 saturation
    @(posedge clk); #1;
    exP[5] = 32'hFFFF_FFFE; exB[5] = 48'hFFFF_FFFF_FF00;
    eExP[5] = 32'hFFFF_FFFE; eExB[5] = 48'hFFFF_FFFF_FF00;
    doPacket(1'b1, 4'd5, 4'b0000, 2, 16'h0200, 32'hD000);
    doPacket(1'b1, 4'd5, 4'b0000, 1, 16'h0001, 32'hE000);
    chk(exP[5] == 32'hFFFF_FFFF, "R6 packet count saturated", 64'(exP[5]), 64'hFFFF_FFFF);
    chk(exB[5] == 48'hFFFF_FFFF_FFFF, "R7 byte count saturated", 64'(exB[5]), 64'hFFFF_FFFF_FFFF);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule